// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global record of the most recent resolved branch directions. That record is joined with the low-order bits of the branch address to choose one saturating counter. Each table row holds 2^m counters, one for each history pattern. A plain bimodal table has one counter per row; here the recent path through the program decides which counter a branch uses. There is no tag check, so branches that share the same index bits share counters.

A fetch stage sends a PC on the lookup request channel. One cycle later it receives the predicted direction on the response channel, together with the history snapshot that was used. It keeps that snapshot with the branch. When the branch resolves, it sends the PC, the snapshot and the real outcome on the update channel. The update trains exactly the counter the lookup used and shifts the outcome into the global history.

Both request and response follow valid/ready rules:
- A lookup is accepted on a cycle where `lk_valid` and `lk_ready` are both high.
- `lk_ready` is high whenever the response slot is empty or is being drained in that same cycle.
- A response waiting with `pr_ready` low keeps its data unchanged.
- The update channel never applies back-pressure: `up_ready` is always high.

Top module: `corr_bpred`

## Requirements
- R1: After reset the global history is all zeros, every counter holds the weakly-not-taken value 2^(n-1)-1 (binary 01 for n=2), `pr_valid` is low, and `lk_ready` and `up_ready` are high.
- R2: A lookup accepted at a clock edge raises `pr_valid` after that edge. `pr_taken` is the most significant bit of the counter addressed by {PC[PC_SHIFT +: log2(ENTRIES)], global history} (1 = taken). `pr_hist` is the history value used for that lookup.
- R3: On update a counter moves up by one for taken and down by one for not taken, saturating at 2^n-1 and at 0.
- R4: With n=2, a counter at strongly taken (11) still predicts taken after one not-taken update and predicts not taken after a second one.
- R5: An update writes only the counter at {update PC index bits, `up_hist`}. Every other counter, including the other history slots of the same row, keeps its value.
- R6: Each update shifts the resolved outcome into history bit 0 and moves older bits up by one place, dropping the oldest. Without an update the history is unchanged.
- R7: PC bits above the index field and below PC_SHIFT play no part in counter selection, so PCs that differ only there share counters.
- R8: When a lookup and an update are accepted in the same cycle, the lookup returns the counter value and the history from before that update.
- R9: While `pr_valid` is high and `pr_ready` is low, `pr_taken` and `pr_hist` hold steady and `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | PC_W | Address of the branch to predict |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer takes the response |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_BITS | History snapshot used for this prediction |
| up_valid | input | 1 | Resolved branch update valid |
| up_ready | output | 1 | Always high; updates are never stalled |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_BITS | Snapshot returned by the matching lookup |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A wrong counter or history value becomes visible only through later predictions. A bad counter step shows on the next lookup of that row whose history matches the trained slot. A bad history shift shows at once in the `pr_hist` of the next accepted lookup. A write that lands in the wrong slot or row stays hidden until some branch reads that slot, possibly many cycles later. For this reason the bench runs a full shadow model on every cycle and steers the history to specific patterns so that it can read back each slot on demand.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Saturating step for counters up to 8 bits wide.
  function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                          input logic [7:0] top,
                                          input logic       up);
    if (up) return (cur == top) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [HB-1:0] hist
);

  logic [HB-1:0] hist_nxt;

  generate
    if (HB == 1) begin : g_one
      assign hist_nxt = din;
    end else begin : g_many
      assign hist_nxt = {hist[HB-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= hist_nxt;
  end

  p_shift_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(din));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

  generate
    if (HB > 1) begin : g_chk_up
      p_shift_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[HB-1:1] == $past(hist[HB-2:0]));
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int AW = 10,
  parameter int CB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [CB-1:0] rd_ctr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_up
);

  localparam int DEPTH = 1 << AW;
  localparam logic [CB-1:0] TOP  = CB'((1 << CB) - 1);
  localparam logic [CB-1:0] INIT = CB'((1 << (CB - 1)) - 1);

  logic [CB-1:0] mem [DEPTH];
  logic [CB-1:0] old_ctr;
  logic [CB-1:0] new_ctr;
  logic [7:0]    step8;

  assign old_ctr = mem[wr_addr];
  assign step8   = bp_pkg::ctr_step(8'(old_ctr), 8'(TOP), wr_up);
  assign new_ctr = step8[CB-1:0];
  assign rd_ctr  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_addr] <= new_ctr;
    end
  end

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_up && old_ctr == TOP |=> mem[$past(wr_addr)] == TOP);

  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_up && old_ctr == '0 |=> mem[$past(wr_addr)] == '0);

  p_other_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || rd_addr != wr_addr) |=> mem[$past(rd_addr)] == $past(rd_ctr));

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W      = 32,
  parameter int PC_SHIFT  = 2,
  parameter int ENTRIES   = 256,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic [PC_W-1:0]      lk_pc,
  output logic                 pr_valid,
  input  logic                 pr_ready,
  output logic                 pr_taken,
  output logic [HIST_BITS-1:0] pr_hist,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic [PC_W-1:0]      up_pc,
  input  logic [HIST_BITS-1:0] up_hist,
  input  logic                 up_taken
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int AW    = IDX_W + HIST_BITS;

  logic [HIST_BITS-1:0] ghist;
  logic [AW-1:0]        rd_addr;
  logic [AW-1:0]        wr_addr;
  logic [CTR_BITS-1:0]  rd_ctr;
  logic                 lk_fire;
  logic                 up_fire;
  logic                 unused_bits;

  assign lk_ready = !pr_valid || pr_ready;
  assign up_ready = 1'b1;
  assign lk_fire  = lk_valid && lk_ready;
  assign up_fire  = up_valid;

  assign rd_addr = {lk_pc[PC_SHIFT +: IDX_W], ghist};
  assign wr_addr = {up_pc[PC_SHIFT +: IDX_W], up_hist};
  assign unused_bits = ^{lk_pc, up_pc, rd_ctr};

  bp_ghist #(.HB(HIST_BITS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (up_fire),
    .din      (up_taken),
    .hist     (ghist)
  );

  bp_ctr_table #(.AW(AW), .CB(CTR_BITS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_ctr  (rd_ctr),
    .wr_en   (up_fire),
    .wr_addr (wr_addr),
    .wr_up   (up_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_taken <= 1'b0;
      pr_hist  <= '0;
    end else if (lk_fire) begin
      pr_valid <= 1'b1;
      pr_taken <= rd_ctr[CTR_BITS-1];
      pr_hist  <= ghist;
    end else if (pr_ready) begin
      pr_valid <= 1'b0;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !pr_valid);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> pr_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_taken) && $stable(pr_hist));

endmodule

// File: tb/corr_bpred_test.sv
module corr_bpred_test;

  localparam int PW = 32, SH = 2, NE = 256, HB = 2, CB = 2;
  localparam int NCTR = NE * 4;
  localparam logic [31:0] PC_A    = 32'h40;
  localparam logic [31:0] PC_A2   = 32'h440;
  localparam logic [31:0] PC_SINK = 32'h3FC;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, pr_ready = 1, up_valid = 0, up_taken = 0;
  logic [PW-1:0] lk_pc = '0, up_pc = '0;
  logic [HB-1:0] up_hist = '0;
  logic lk_ready, pr_valid, pr_taken, up_ready;
  logic [HB-1:0] pr_hist;

  corr_bpred #(.PC_W(PW), .PC_SHIFT(SH), .ENTRIES(NE), .HIST_BITS(HB), .CTR_BITS(CB)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken), .pr_hist(pr_hist),
    .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc), .up_hist(up_hist),
    .up_taken(up_taken)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int ref_ctr [NCTR];
  logic [HB-1:0] ref_hist;
  logic exp_pv, exp_taken;
  logic [HB-1:0] exp_h;
  bit finished = 0;

  function automatic int f_addr(input logic [31:0] pc, input logic [HB-1:0] h);
    return int'(pc[9:2]) * 4 + int'(h);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input logic lv, input logic [31:0] lpc, input logic uv,
                      input logic [31:0] upc, input logic [HB-1:0] uh,
                      input logic ut, input logic prdy);
    logic acc, nt;
    logic [HB-1:0] nh;
    lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc;
    up_hist = uh; up_taken = ut; pr_ready = prdy;
    #1;
    chk("R9 lk_ready", int'(lk_ready), int'(!exp_pv || prdy));
    acc = lv && (!exp_pv || prdy);
    nt  = ref_ctr[f_addr(lpc, ref_hist)] >= 2;
    nh  = ref_hist;
    @(posedge clk);
    if (acc) begin
      exp_pv = 1; exp_taken = nt; exp_h = nh;
    end else if (prdy) exp_pv = 0;
    if (uv) begin
      int a = f_addr(upc, uh);
      if (ut) ref_ctr[a] = (ref_ctr[a] == 3) ? 3 : ref_ctr[a] + 1;
      else    ref_ctr[a] = (ref_ctr[a] == 0) ? 0 : ref_ctr[a] - 1;
      ref_hist = {ref_hist[0], ut};
    end
    @(negedge clk);
    lk_valid = 0; up_valid = 0; pr_ready = 1;
    chk("R2 pr_valid", int'(pr_valid), int'(exp_pv));
    if (exp_pv) begin
      chk("R2 pr_taken", int'(pr_taken), int'(exp_taken));
      chk("R6 pr_hist", int'(pr_hist), int'(exp_h));
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [HB-1:0] h, input logic t);
    step(0, '0, 1, pc, h, t, 1);
  endtask

  task automatic set_hist(input logic [HB-1:0] h);
    upd(PC_SINK, ref_hist, h[1]);
    upd(PC_SINK, ref_hist, h[0]);
  endtask

  task automatic look(input logic [31:0] pc, input int exp, input string tag);
    step(1, pc, 0, '0, '0, 0, 1);
    chk(tag, int'(pr_taken), exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCTR; i++) ref_ctr[i] = 1;
    ref_hist = '0; exp_pv = 0; exp_taken = 0; exp_h = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pr_valid", int'(pr_valid), 0);
    chk("R1 lk_ready", int'(lk_ready), 1);
    chk("R1 up_ready", int'(up_ready), 1);
    look(PC_A, 0, "R1 weak-not-taken");
    chk("R1 hist zero", int'(pr_hist), 0);

    // R3 / R4: train slot 00 of row A up to saturation, then walk down
    upd(PC_A, 2'b00, 1); upd(PC_A, 2'b00, 1); upd(PC_A, 2'b00, 1);
    set_hist(2'b00); look(PC_A, 1, "R3 saturated high");
    upd(PC_A, 2'b00, 0);
    set_hist(2'b00); look(PC_A, 1, "R4 one miss keeps taken");
    upd(PC_A, 2'b00, 0);
    set_hist(2'b00); look(PC_A, 0, "R4 second miss flips");
    upd(PC_A, 2'b00, 0); upd(PC_A, 2'b00, 0); upd(PC_A, 2'b00, 0);
    upd(PC_A, 2'b00, 1);
    set_hist(2'b00); look(PC_A, 0, "R3 saturated low");

    // R5: other slots of row A untouched, then train slot 11 only
    set_hist(2'b01); look(PC_A, 0, "R5 slot 01 untouched");
    upd(PC_A, 2'b11, 1); upd(PC_A, 2'b11, 1);
    set_hist(2'b11); look(PC_A, 1, "R5 slot 11 trained");
    set_hist(2'b00); look(PC_A, 0, "R5 slot 00 kept");

    // R6: shift order
    upd(PC_SINK, 2'b00, 1); upd(PC_SINK, 2'b00, 0);
    look(PC_SINK, int'(ref_ctr[f_addr(PC_SINK, 2'b10)] >= 2), "R6 lookup");
    chk("R6 shift order", int'(pr_hist), 2);

    // R7: aliasing through upper PC bits
    set_hist(2'b11); look(PC_A2, 1, "R7 alias shares counter");

    // R8: lookup and update in the same cycle
    set_hist(2'b00);
    step(1, PC_A, 1, PC_A, 2'b00, 1, 1);
    chk("R8 old counter", int'(pr_taken), 0);
    chk("R8 old history", int'(pr_hist), 0);
    set_hist(2'b00); look(PC_A, 1, "R8 update landed");

    // R9: back-pressure
    step(1, PC_A, 0, '0, '0, 0, 0);
    step(1, PC_SINK, 0, '0, '0, 0, 0);
    chk("R9 stalled not ready", int'(lk_ready), 0);
    chk("R9 held taken", int'(pr_taken), 1);
    step(1, PC_SINK, 0, '0, '0, 0, 1);

    // Random traffic over a small aliased PC pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] p1, p2;
      logic [HB-1:0] h;
      p1 = ($urandom & 32'hFFFF_FC00) | ($urandom_range(0, 7) << 2);
      p2 = ($urandom & 32'hFFFF_FC00) | ($urandom_range(0, 7) << 2);
      h  = ($urandom_range(0, 3) == 0) ? HB'($urandom) : ref_hist;
      step(logic'($urandom_range(0, 1)), p1, logic'($urandom_range(0, 1)), p2, h,
           logic'($urandom_range(0, 2) != 0), logic'($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule